// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands in a four-stage pipeline. Each operand has three parts: a sign bit, an unsigned binary fraction of `FRAC_W` bits with value below one, and a two's-complement exponent of `EXP_W` bits. The value of an operand is (-1)^sign x 0.frac x 2^exp. The block accepts one operation on every clock. Each result leaves the pipeline four clocks after its operation entered it, in the order of issue.

The first stage subtracts the exponents and orders the operands by exponent. The second stage takes the larger exponent and shifts the other fraction right by the exponent difference. The third stage adds or subtracts the magnitudes according to the effective signs. The fourth stage normalizes the result. A carry out of the fraction gives a one-place right shift and an exponent increment. A cancellation gives a left shift until the top fraction bit is one, with the exponent lowered by the shift count. If the normalized exponent leaves the representable range, a sticky error flag is raised, and only reset clears it. Rounding, infinities, NaNs and denormals are not handled.

Top module: `fpa_pipe`

## Requirements
- R1: `out_valid_o` is high exactly 4 clock cycles after `in_valid_i` was high at a rising edge. Operations issued on consecutive cycles produce results on consecutive cycles, in issue order.
- R2: When the effective signs are equal, the result magnitude is the sum of the aligned magnitudes and the result sign is that common sign. The sign of b is `b_sign_i` XOR `sub_i`.
- R3: With `sub_i`=1 the result is a minus b. When the effective signs differ, the result sign is the sign of the operand with the larger aligned magnitude.
- R4: The result exponent before normalization is the larger input exponent. The other fraction is shifted right by the exponent difference, and the bits shifted out are dropped (truncation).
- R5: An exponent difference of `FRAC_W` (24) or more makes the smaller operand contribute zero. The result then equals the larger operand, normalized.
- R6: When the magnitude sum reaches or exceeds one, the fraction is shifted right by one and the exponent is increased by one.
- R7: On cancellation, the fraction is shifted left until bit 23 is 1, and the exponent is decreased by the shift count.
- R8: A zero magnitude result gives sign 0, exponent 0 and fraction 0, with no error.
- R9: Every valid result either has `res_frac_o[23]`=1 or is all zero.
- R10: If the normalized exponent is above 127 or below -128, the result is forced to all zero and `err_o` is set. `err_o` stays set until reset, and it is updated on the same edge as the result that caused it.
- R11: While reset is asserted and after it, `out_valid_o` and `err_o` are 0 until new operations complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation valid |
| sub_i | input | 1 | 1 = subtract b from a, 0 = add |
| a_sign_i | input | 1 | Sign of operand a |
| a_exp_i | input | 8 | Exponent of a, two's complement |
| a_frac_i | input | 24 | Fraction of a |
| b_sign_i | input | 1 | Sign of operand b |
| b_exp_i | input | 8 | Exponent of b, two's complement |
| b_frac_i | input | 24 | Fraction of b |
| out_valid_o | output | 1 | Result valid |
| res_sign_o | output | 1 | Result sign |
| res_exp_o | output | 8 | Result exponent, two's complement |
| res_frac_o | output | 24 | Normalized result fraction |
| err_o | output | 1 | Sticky exponent range error |

## Verification
The hardest cases to reach are those in the fourth stage at the edges of its range. One is a cancellation that leaves a single low bit and needs a 23-place left shift. Others are a carry at the largest exponent and a cancellation at the smallest. Random operands almost never produce them. The bench therefore issues directed operand pairs for each of them: equal exponents with fractions one LSB apart, 127 plus a carry, and -128 with a difference that needs a left shift. These pairs are mixed back-to-back with random traffic, so the error flag and the data path are exercised while the pipeline is full. A reset in the middle of the run then shows that the error flag clears.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int unsigned EXP_W_DEF  = 8;
  localparam int unsigned FRAC_W_DEF = 24;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fpa_op_e;
endpackage

// File: rtl/fpa_cmp.sv
module fpa_cmp #(
  parameter int unsigned EXP_W  = fpa_pkg::EXP_W_DEF,
  parameter int unsigned FRAC_W = fpa_pkg::FRAC_W_DEF,
  localparam int unsigned SH_W  = EXP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sub_i,
  input  logic              a_sign_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic              b_sign_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  output logic              valid_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              big_sign_o,
  output logic [FRAC_W-1:0] big_frac_o,
  output logic              sml_sign_o,
  output logic [FRAC_W-1:0] sml_frac_o,
  output logic [SH_W-1:0]   shamt_o
);
  logic [SH_W-1:0] diff;
  logic            a_big, b_sign_eff;

  always_comb begin
    diff       = {a_exp_i[EXP_W-1], a_exp_i} - {b_exp_i[EXP_W-1], b_exp_i};
    a_big      = ~diff[SH_W-1];
    b_sign_eff = b_sign_i ^ (sub_i == fpa_pkg::OP_SUB);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      exp_o      <= '0;
      big_sign_o <= 1'b0;
      big_frac_o <= '0;
      sml_sign_o <= 1'b0;
      sml_frac_o <= '0;
      shamt_o    <= '0;
    end else begin
      valid_o    <= valid_i;
      exp_o      <= a_big ? a_exp_i : b_exp_i;
      big_sign_o <= a_big ? a_sign_i : b_sign_eff;
      big_frac_o <= a_big ? a_frac_i : b_frac_i;
      sml_sign_o <= a_big ? b_sign_eff : a_sign_i;
      sml_frac_o <= a_big ? b_frac_i : a_frac_i;
      shamt_o    <= a_big ? diff : -diff;
    end
  end

  p_exp_pick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($signed(exp_o) >= $signed($past(a_exp_i)) &&
                 $signed(exp_o) >= $signed($past(b_exp_i))));
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int unsigned EXP_W  = fpa_pkg::EXP_W_DEF,
  parameter int unsigned FRAC_W = fpa_pkg::FRAC_W_DEF,
  localparam int unsigned SH_W  = EXP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              big_sign_i,
  input  logic [FRAC_W-1:0] big_frac_i,
  input  logic              sml_sign_i,
  input  logic [FRAC_W-1:0] sml_frac_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic              valid_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              big_sign_o,
  output logic [FRAC_W-1:0] big_frac_o,
  output logic              sml_sign_o,
  output logic [FRAC_W-1:0] sml_frac_o
);
  logic [FRAC_W-1:0] shifted;

  always_comb begin
    if (shamt_i >= SH_W'(FRAC_W)) shifted = '0;
    else                           shifted = sml_frac_i >> shamt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      exp_o      <= '0;
      big_sign_o <= 1'b0;
      big_frac_o <= '0;
      sml_sign_o <= 1'b0;
      sml_frac_o <= '0;
    end else begin
      valid_o    <= valid_i;
      exp_o      <= exp_i;
      big_sign_o <= big_sign_i;
      big_frac_o <= big_frac_i;
      sml_sign_o <= sml_sign_i;
      sml_frac_o <= shifted;
    end
  end

  p_far_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && shamt_i >= SH_W'(FRAC_W)) |=> (sml_frac_o == '0));
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub #(
  parameter int unsigned EXP_W  = fpa_pkg::EXP_W_DEF,
  parameter int unsigned FRAC_W = fpa_pkg::FRAC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              big_sign_i,
  input  logic [FRAC_W-1:0] big_frac_i,
  input  logic              sml_sign_i,
  input  logic [FRAC_W-1:0] sml_frac_i,
  output logic              valid_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              sign_o,
  output logic [FRAC_W:0]   mag_o
);
  logic [FRAC_W:0] mag_d;
  logic            sign_d;

  always_comb begin
    if (big_sign_i == sml_sign_i) begin
      mag_d  = {1'b0, big_frac_i} + {1'b0, sml_frac_i};
      sign_d = big_sign_i;
    end else if (big_frac_i >= sml_frac_i) begin
      mag_d  = {1'b0, big_frac_i - sml_frac_i};
      sign_d = big_sign_i;
    end else begin
      mag_d  = {1'b0, sml_frac_i - big_frac_i};
      sign_d = sml_sign_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      exp_o   <= '0;
      sign_o  <= 1'b0;
      mag_o   <= '0;
    end else begin
      valid_o <= valid_i;
      exp_o   <= exp_i;
      sign_o  <= sign_d;
      mag_o   <= mag_d;
    end
  end

  // differing signs never carry
  p_no_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && big_sign_i != sml_sign_i) |=> !mag_o[FRAC_W]);
endmodule

// File: rtl/fpa_norm.sv
module fpa_norm #(
  parameter int unsigned EXP_W  = fpa_pkg::EXP_W_DEF,
  parameter int unsigned FRAC_W = fpa_pkg::FRAC_W_DEF,
  localparam int unsigned LZ_W  = $clog2(FRAC_W + 1),
  localparam int unsigned EW2   = EXP_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              sign_i,
  input  logic [FRAC_W:0]   mag_i,
  output logic              valid_o,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              err_o
);
  localparam int EMAX = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN = -(1 << (EXP_W - 1));

  logic [LZ_W-1:0]       lz;
  logic signed [EW2-1:0] exp_x;
  logic [FRAC_W-1:0]     frac_x;
  logic                  is_zero, range_err;

  always_comb begin
    lz = LZ_W'(FRAC_W);
    for (int i = 0; i < FRAC_W; i++) begin
      if (mag_i[i]) lz = LZ_W'(FRAC_W - 1 - i);
    end
  end

  always_comb begin
    is_zero = (mag_i == '0);
    if (mag_i[FRAC_W]) begin
      frac_x = mag_i[FRAC_W:1];
      exp_x  = EW2'($signed(exp_i)) + EW2'(1);
    end else begin
      frac_x = mag_i[FRAC_W-1:0] << lz;
      exp_x  = EW2'($signed(exp_i)) - $signed(EW2'(lz));
    end
    range_err = !is_zero && ((exp_x > EW2'(EMAX)) || (exp_x < EW2'(EMIN)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      exp_o   <= '0;
      frac_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (is_zero || range_err) begin
        sign_o <= 1'b0;
        exp_o  <= '0;
        frac_o <= '0;
      end else begin
        sign_o <= sign_i;
        exp_o  <= exp_x[EXP_W-1:0];
        frac_o <= frac_x;
      end
      if (valid_i && range_err) err_o <= 1'b1;
    end
  end

  p_normal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (frac_o[FRAC_W-1] || (frac_o == '0 && exp_o == '0 && !sign_o)));
  p_sticky_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_o) |-> err_o);
  p_carry_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mag_i[FRAC_W] && !range_err) |=> (frac_o == $past(mag_i[FRAC_W:1])));
  p_zero_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mag_i == '0) |=> (frac_o == '0 && exp_o == '0 && !sign_o));
endmodule

// File: rtl/fpa_pipe.sv
module fpa_pipe #(
  parameter int unsigned EXP_W  = fpa_pkg::EXP_W_DEF,
  parameter int unsigned FRAC_W = fpa_pkg::FRAC_W_DEF,
  localparam int unsigned SH_W  = EXP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              sub_i,
  input  logic              a_sign_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic              b_sign_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  output logic              out_valid_o,
  output logic              res_sign_o,
  output logic [EXP_W-1:0]  res_exp_o,
  output logic [FRAC_W-1:0] res_frac_o,
  output logic              err_o
);
  logic              s1_valid, s1_bsign, s1_ssign;
  logic [EXP_W-1:0]  s1_exp;
  logic [FRAC_W-1:0] s1_bfrac, s1_sfrac;
  logic [SH_W-1:0]   s1_shamt;
  logic              s2_valid, s2_bsign, s2_ssign;
  logic [EXP_W-1:0]  s2_exp;
  logic [FRAC_W-1:0] s2_bfrac, s2_sfrac;
  logic              s3_valid, s3_sign;
  logic [EXP_W-1:0]  s3_exp;
  logic [FRAC_W:0]   s3_mag;

  fpa_cmp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cmp (
    .clk_i, .rst_ni, .valid_i(in_valid_i), .sub_i,
    .a_sign_i, .a_exp_i, .a_frac_i, .b_sign_i, .b_exp_i, .b_frac_i,
    .valid_o(s1_valid), .exp_o(s1_exp), .big_sign_o(s1_bsign), .big_frac_o(s1_bfrac),
    .sml_sign_o(s1_ssign), .sml_frac_o(s1_sfrac), .shamt_o(s1_shamt)
  );

  fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .clk_i, .rst_ni, .valid_i(s1_valid), .exp_i(s1_exp),
    .big_sign_i(s1_bsign), .big_frac_i(s1_bfrac), .sml_sign_i(s1_ssign),
    .sml_frac_i(s1_sfrac), .shamt_i(s1_shamt),
    .valid_o(s2_valid), .exp_o(s2_exp), .big_sign_o(s2_bsign), .big_frac_o(s2_bfrac),
    .sml_sign_o(s2_ssign), .sml_frac_o(s2_sfrac)
  );

  fpa_addsub #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addsub (
    .clk_i, .rst_ni, .valid_i(s2_valid), .exp_i(s2_exp),
    .big_sign_i(s2_bsign), .big_frac_i(s2_bfrac), .sml_sign_i(s2_ssign),
    .sml_frac_i(s2_sfrac),
    .valid_o(s3_valid), .exp_o(s3_exp), .sign_o(s3_sign), .mag_o(s3_mag)
  );

  fpa_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk_i, .rst_ni, .valid_i(s3_valid), .exp_i(s3_exp), .sign_i(s3_sign),
    .mag_i(s3_mag),
    .valid_o(out_valid_o), .sign_o(res_sign_o), .exp_o(res_exp_o),
    .frac_o(res_frac_o), .err_o
  );

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i, 4));
endmodule

// File: tb/tb_fpa_pipe.sv
module tb_fpa_pipe;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, sub_i = 1'b0;
  logic        a_sign_i = 1'b0, b_sign_i = 1'b0;
  logic [7:0]  a_exp_i = '0, b_exp_i = '0;
  logic [23:0] a_frac_i = '0, b_frac_i = '0;
  logic        out_valid_o, res_sign_o, err_o;
  logic [7:0]  res_exp_o;
  logic [23:0] res_frac_o;

  fpa_pipe dut (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    logic        sign;
    logic [7:0]  exp;
    logic [23:0] frac;
    logic        err;
    int          issue;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0, cyc = 0;
  logic err_sticky = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  // reference built from the value definitions
  function automatic exp_t model(input logic sa, input int ea, input longint fa,
                                 input logic sb, input int eb, input longint fb,
                                 input logic sub);
    exp_t   r;
    int     e, d;
    longint s, m;
    d = ea - eb;
    if (d >= 0) begin
      e = ea;
      fb = (d >= 24) ? 0 : (fb >> d);
    end else begin
      e = eb;
      fa = (-d >= 24) ? 0 : (fa >> (-d));
    end
    s = (sa ? -fa : fa) + ((sb ^ sub) ? -fb : fb);
    r.sign = 1'b0; r.exp = '0; r.frac = '0; r.err = 1'b0;
    if (s == 0) return r;
    m = (s < 0) ? -s : s;
    if (m >= 64'sd16777216) begin m = m >> 1; e = e + 1; end
    while (m < 64'sd8388608) begin m = m << 1; e = e - 1; end
    if (e > 127 || e < -128) begin r.err = 1'b1; return r; end
    r.sign = (s < 0);
    r.exp  = 8'(e);
    r.frac = 24'(m);
    return r;
  endfunction

  task automatic issue(input logic sa, input int ea, input logic [23:0] fa,
                       input logic sb, input int eb, input logic [23:0] fb,
                       input logic sub, input string tag);
    exp_t e;
    @(negedge clk_i);
    e = model(sa, ea, longint'(fa), sb, eb, longint'(fb), sub);
    err_sticky = err_sticky | e.err;
    e.err   = err_sticky;
    e.issue = cyc;
    e.tag   = tag;
    q.push_back(e);
    in_valid_i = 1'b1; sub_i = sub;
    a_sign_i = sa; a_exp_i = 8'(ea); a_frac_i = fa;
    b_sign_i = sb; b_exp_i = 8'(eb); b_frac_i = fb;
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    a_frac_i = 24'hABCDEF; b_frac_i = 24'h123456;
    repeat (n) @(negedge clk_i);
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1 unexpected result");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.issue + 4,
            $sformatf("R1 latency act=%0d exp=4", cyc - e.issue));
        chk({res_sign_o, res_exp_o, res_frac_o} == {e.sign, e.exp, e.frac},
            $sformatf("%s result act=%b/%h/%h exp=%b/%h/%h", e.tag,
                      res_sign_o, res_exp_o, res_frac_o, e.sign, e.exp, e.frac));
        chk(err_o == e.err,
            $sformatf("R10 err (%s) act=%b exp=%b", e.tag, err_o, e.err));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0 && err_o == 1'b0,
        $sformatf("R11 reset state act=%b%b exp=00", out_valid_o, err_o));
    rst_ni = 1'b1;
    // R2 same signs, different exponents
    issue(0, 3, 24'h800000, 0, 1, 24'h800000, 0, "R2");
    // R6 carry: 0.5+0.5 -> 0.5 x 2^4
    issue(0, 3, 24'h800000, 0, 3, 24'h800000, 0, "R6");
    // R2 both negative
    issue(1, -5, 24'hC00000, 1, -6, 24'h900000, 0, "R2");
    // R3 subtract, a larger
    issue(0, 2, 24'hC00000, 0, 2, 24'h800000, 1, "R3");
    // R3 subtract, b larger -> negative
    issue(0, 2, 24'h900000, 0, 4, 24'hA00000, 1, "R3");
    // R3 subtract of negative b equals add
    issue(0, 0, 24'h812345, 1, 0, 24'h876543, 1, "R3");
    // R4 truncation of shifted-out bits
    issue(0, 10, 24'h800000, 0, 9, 24'h800001, 0, "R4");
    issue(0, -20, 24'hF00000, 0, -13, 24'h80000F, 0, "R4");
    // R5 large differences, both orders
    issue(0, 30, 24'hA5A5A5, 0, 6, 24'hFFFFFF, 0, "R5");
    issue(1, -40, 24'hFFFFFF, 0, 20, 24'h876543, 1, "R5");
    issue(0, 23, 24'h800000, 0, 0, 24'hFFFFFF, 0, "R4");
    // R7 deep cancellation
    issue(0, 5, 24'h800001, 0, 5, 24'h800000, 1, "R7");
    issue(1, 0, 24'hFFFFFF, 0, 1, 24'h800000, 0, "R7");
    // R8 exact cancellation
    issue(0, 7, 24'h9ABCDE, 0, 7, 24'h9ABCDE, 1, "R8");
    issue(1, -3, 24'h000000, 0, -3, 24'h000000, 0, "R8");
    // R9 unnormalized inputs get normalized
    issue(0, 4, 24'h000300, 0, 4, 24'h000100, 0, "R9");
    idle(8);
    chk(q.size() == 0 && err_o == 1'b0,
        $sformatf("R1 drain act=%0d/%b exp=0/0", q.size(), err_o));
    // R10 overflow then sticky across normal results
    issue(0, 127, 24'h800000, 0, 127, 24'h800000, 0, "R10");
    issue(0, 1, 24'h800000, 0, 1, 24'h400000, 0, "R10");
    // R10 underflow
    issue(0, -128, 24'h800000, 0, -128, 24'h400000, 1, "R10");
    // random back-to-back traffic
    for (int i = 0; i < 60; i++) begin
      issue(1'($urandom), int'($urandom_range(0, 120)) - 60, 24'($urandom) | 24'h800000,
            1'($urandom), int'($urandom_range(0, 120)) - 60,
            (i % 4 == 0) ? 24'($urandom) : (24'($urandom) | 24'h800000),
            1'($urandom), "R2");
    end
    idle(8);
    chk(q.size() == 0, $sformatf("R1 drain act=%0d exp=0", q.size()));
    // R11 reset clears sticky error
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0 && err_o == 1'b0,
        $sformatf("R11 mid reset act=%b%b exp=00", out_valid_o, err_o));
    err_sticky = 1'b0;
    rst_ni = 1'b1;
    issue(0, 126, 24'h800000, 0, 125, 24'h800000, 0, "R11");
    idle(8);
    chk(err_o == 1'b0, $sformatf("R11 err after reset act=%b exp=0", err_o));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule